// File: doc/BRIEF.md
# D-PHY Data Lane High-Speed Burst Transmitter

This block drives one data lane of a D-PHY transmitter. While idle it keeps the lane in the low-power stop state. When a byte is waiting and the clock lane has granted the start, it steps the lane through the low-power request and prepare phases. It then holds the high-speed zero level, sends a sync byte and serialises payload bytes from a valid/ready byte stream, one bit per clock. When the stream runs dry it ends the burst with a trail period and an exit period, then returns the lane to stop.

The length of each phase is programmable as a count of units. One unit is `UNIT_CYC` clocks, which is one byte time when the clock runs at the bit rate. Two run-time controls change the behaviour. One selects whether each byte goes out most-significant or least-significant bit first. The other forces the lane back into stop at once. The high-speed and low-power driver enables normally follow the lane phase, but each can instead take a fixed value from an input. A 4-bit status word reports stop and high-speed activity.

Top module: `dlane_hs_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the lane is in stop: `lp_p`=1, `lp_n`=1, `hs_bit`=0, `in_ready`=0, `lane_status`=4'b0100.
- R2: A burst starts only from stop, and only when `in_valid`=1, `clk_lane_go`=1 and `force_stop`=0 at the same clock edge. The lane then drives `{lp_p,lp_n}`=01 for the LPX period, then 00 for the prepare period, then the high-speed zero period with `hs_bit`=0. It never goes straight from 11 to 00.
- R3: Phase lengths are in units of `UNIT_CYC` clocks (default 8), and a field value of 0 counts as 1. LPX comes from `lpx_units`. The fields of `hs_times` are prepare [31:24], zero [23:16], trail [15:8] and exit [7:0].
- R4: After the zero period the lane sends the sync byte 8'hB8, then each accepted payload byte, each byte over 8 consecutive clocks on `hs_bit`.
- R5: `msb_first`=1 sends bit 7 of each byte first and `msb_first`=0 sends bit 0 first. The sync byte follows the same order. The value is sampled when the byte is loaded.
- R6: `in_ready` is 1 only in the final bit clock of the sync byte or of a payload byte, and only if `force_stop`=0. A byte is taken when `in_valid` is 1 in that cycle, and its first bit appears in the next clock.
- R7: If `in_valid` is 0 in the final bit clock, the lane drives the inverse of the bit just sent for the trail period. It then drives `{lp_p,lp_n}`=11 for the exit period and returns to stop, where a new burst may start.
- R8: `force_stop`=1 puts the lane in stop at the next edge and holds it there for as long as it stays 1, whatever `in_valid` and `clk_lane_go` do. While it is 1, `in_ready` is 0.
- R9: Without override, `hs_drv_en` is 1 during zero, sync/payload and trail, and `lp_drv_en` is 1 during stop, LPX, prepare and exit. When `hs_en_ovr` or `lp_en_ovr` is 1, that enable equals `hs_en_val` or `lp_en_val` respectively.
- R10: `lane_status` is {1'b0, stop, ulps, hs_active}. Bit 2 is 1 in stop, bit 1 (ultra-low-power) is always 0, and bit 0 is 1 during zero, sync/payload and trail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_byte | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Payload byte taken in this cycle when valid |
| hs_times | input | 4*FIELD_W | Prepare, zero, trail and exit lengths in units |
| lpx_units | input | FIELD_W | LPX length in units |
| msb_first | input | 1 | Bit order select |
| force_stop | input | 1 | Force lane into stop |
| hs_en_ovr | input | 1 | Take HS enable from `hs_en_val` |
| hs_en_val | input | 1 | Override value for HS enable |
| lp_en_ovr | input | 1 | Take LP enable from `lp_en_val` |
| lp_en_val | input | 1 | Override value for LP enable |
| clk_lane_go | input | 1 | Start grant from the clock lane |
| hs_bit | output | 1 | Serial high-speed data |
| lp_p | output | 1 | Low-power level, positive line |
| lp_n | output | 1 | Low-power level, negative line |
| hs_drv_en | output | 1 | High-speed driver enable |
| lp_drv_en | output | 1 | Low-power driver enable |
| lane_status | output | 4 | {0, stop, ulps, hs_active} |

## Verification
The line levels, enables and status are decoded straight from the phase register, so a wrong phase shows at the ports in the same cycle. A phase counter that is off by one shows as a phase boundary one clock early or late. A misloaded or misordered shift register shows on `hs_bit` in the first wrong bit clock, and a wrong trail level shows in the first trail cycle. Because every output is compared with the model on every clock, any of these faults is reported within one cycle of the point where it first becomes visible.

// File: rtl/dlane_pkg.sv
package dlane_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] SYNC_PATTERN = 8'hB8;

   typedef enum logic [2:0] {
      S_STOP  = 3'd0,
      S_LPX   = 3'd1,
      S_PREP  = 3'd2,
      S_ZERO  = 3'd3,
      S_SER   = 3'd4,
      S_TRAIL = 3'd5,
      S_EXIT  = 3'd6
   } lane_st_t;
endpackage

// File: rtl/dlane_phase_timer.sv
module dlane_phase_timer #(
   parameter int FIELD_W  = 8,
   parameter int UNIT_CYC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FIELD_W-1:0] units,
   output logic               expired
);
   localparam int  CNT_W = FIELD_W + $clog2(UNIT_CYC) + 1;
   localparam bit  POW2  = ((UNIT_CYC & (UNIT_CYC - 1)) == 0);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] n_eff;
   logic [CNT_W-1:0] scaled;

   // zero-valued field is stretched to one unit
   assign n_eff = (units == '0) ? CNT_W'(1) : CNT_W'(units);

   generate
      if (POW2) begin : g_shift
         assign scaled = n_eff << $clog2(UNIT_CYC);
      end else begin : g_mult
         assign scaled = n_eff * CNT_W'(UNIT_CYC);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= scaled - CNT_W'(1);
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/dlane_shifter.sv
module dlane_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic              msb_first,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              cur_bit,
   output logic              final_slot
);
   localparam int IDX_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sr;
   logic [BYTE_W-1:0] ordered;
   logic [IDX_W-1:0]  idx;

   // arrange the byte so that the bit to send first sits at position 0
   generate
      for (genvar i = 0; i < BYTE_W; i++) begin : g_order
         assign ordered[i] = msb_first ? byte_in[BYTE_W-1-i] : byte_in[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         idx <= '0;
      end else if (load) begin
         sr  <= ordered;
         idx <= '0;
      end else if (shift) begin
         sr  <= sr >> 1;
         idx <= idx + IDX_W'(1);
      end
   end

   assign cur_bit    = sr[0];
   assign final_slot = (idx == IDX_W'(BYTE_W - 1));
endmodule

// File: rtl/dlane_en_select.sv
module dlane_en_select #(
   parameter int N_EN = 2
) (
   input  logic [N_EN-1:0] ovr,
   input  logic [N_EN-1:0] val,
   input  logic [N_EN-1:0] fsm,
   output logic [N_EN-1:0] en
);
   generate
      for (genvar i = 0; i < N_EN; i++) begin : g_sel
         assign en[i] = ovr[i] ? val[i] : fsm[i];
      end
   endgenerate
endmodule

// File: rtl/dlane_hs_tx.sv
module dlane_hs_tx
   import dlane_pkg::*;
#(
   parameter int FIELD_W  = 8,
   parameter int UNIT_CYC = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           in_byte,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [4*FIELD_W-1:0] hs_times,
   input  logic [FIELD_W-1:0]   lpx_units,
   input  logic                 msb_first,
   input  logic                 force_stop,
   input  logic                 hs_en_ovr,
   input  logic                 hs_en_val,
   input  logic                 lp_en_ovr,
   input  logic                 lp_en_val,
   input  logic                 clk_lane_go,
   output logic                 hs_bit,
   output logic                 lp_p,
   output logic                 lp_n,
   output logic                 hs_drv_en,
   output logic                 lp_drv_en,
   output logic [3:0]           lane_status
);
   localparam int F = FIELD_W;

   generate
      if (FIELD_W < 2 || FIELD_W > 16) begin : g_bad_field
         $error("dlane_hs_tx: FIELD_W must lie in 2..16");
      end
      if (UNIT_CYC < 1 || UNIT_CYC > 64) begin : g_bad_unit
         $error("dlane_hs_tx: UNIT_CYC must lie in 1..64");
      end
   endgenerate

   logic [F-1:0] t_prep, t_zero, t_trail, t_exit;
   assign t_prep  = hs_times[4*F-1:3*F];
   assign t_zero  = hs_times[3*F-1:2*F];
   assign t_trail = hs_times[2*F-1:F];
   assign t_exit  = hs_times[F-1:0];

   lane_st_t          st, st_nx;
   logic              tmr_load, tmr_done;
   logic [F-1:0]      tmr_units;
   logic              ser_load, ser_shift, ser_bit, ser_last;
   logic [BYTE_W-1:0] ser_byte;
   logic              trail_lvl;
   logic              hs_phase;
   logic [1:0]        en_fsm, en_out;

   dlane_phase_timer #(.FIELD_W(F), .UNIT_CYC(UNIT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .units   (tmr_units),
      .expired (tmr_done)
   );

   dlane_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (ser_load),
      .shift      (ser_shift),
      .msb_first  (msb_first),
      .byte_in    (ser_byte),
      .cur_bit    (ser_bit),
      .final_slot (ser_last)
   );

   assign in_ready = (st == S_SER) && ser_last && !force_stop;

   always_comb begin
      st_nx     = st;
      tmr_load  = 1'b0;
      tmr_units = '0;
      ser_load  = 1'b0;
      ser_shift = 1'b0;
      ser_byte  = in_byte;
      if (force_stop) begin
         st_nx = S_STOP;
      end else begin
         unique case (st)
            S_STOP: if (in_valid && clk_lane_go) begin
               st_nx     = S_LPX;
               tmr_load  = 1'b1;
               tmr_units = lpx_units;
            end
            S_LPX: if (tmr_done) begin
               st_nx     = S_PREP;
               tmr_load  = 1'b1;
               tmr_units = t_prep;
            end
            S_PREP: if (tmr_done) begin
               st_nx     = S_ZERO;
               tmr_load  = 1'b1;
               tmr_units = t_zero;
            end
            S_ZERO: if (tmr_done) begin
               st_nx    = S_SER;
               ser_load = 1'b1;
               ser_byte = SYNC_PATTERN;
            end
            S_SER: begin
               ser_shift = 1'b1;
               if (ser_last) begin
                  if (in_valid) begin
                     ser_load = 1'b1;
                  end else begin
                     st_nx     = S_TRAIL;
                     tmr_load  = 1'b1;
                     tmr_units = t_trail;
                  end
               end
            end
            S_TRAIL: if (tmr_done) begin
               st_nx     = S_EXIT;
               tmr_load  = 1'b1;
               tmr_units = t_exit;
            end
            S_EXIT: if (tmr_done) st_nx = S_STOP;
            default: st_nx = S_STOP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_STOP;
         trail_lvl <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == S_SER && ser_last)
            trail_lvl <= ~ser_bit;
      end
   end

   assign hs_phase = (st == S_ZERO) || (st == S_SER) || (st == S_TRAIL);

   always_comb begin
      unique case (st)
         S_SER:   hs_bit = ser_bit;
         S_TRAIL: hs_bit = trail_lvl;
         default: hs_bit = 1'b0;
      endcase
   end

   always_comb begin
      unique case (st)
         S_STOP, S_EXIT: {lp_p, lp_n} = 2'b11;
         S_LPX:          {lp_p, lp_n} = 2'b01;
         default:        {lp_p, lp_n} = 2'b00;
      endcase
   end

   assign en_fsm[0] = hs_phase;
   assign en_fsm[1] = (st == S_STOP) || (st == S_LPX) || (st == S_PREP) || (st == S_EXIT);

   dlane_en_select #(.N_EN(2)) u_en (
      .ovr ({lp_en_ovr, hs_en_ovr}),
      .val ({lp_en_val, hs_en_val}),
      .fsm (en_fsm),
      .en  (en_out)
   );

   assign hs_drv_en   = en_out[0];
   assign lp_drv_en   = en_out[1];
   assign lane_status = {1'b0, (st == S_STOP), 1'b0, hs_phase};
endmodule

// File: rtl/dlane_hs_tx_chk.sv
module dlane_hs_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       force_stop,
   input logic       clk_lane_go,
   input logic       lp_p,
   input logic       lp_n,
   input logic       lp_en_ovr,
   input logic       lp_drv_en,
   input logic [3:0] lane_status
);
   p_force_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      force_stop |=> (lane_status[2] && lp_p && lp_n));

   p_ready_not_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
      force_stop |-> !in_ready);

   p_ready_in_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (lane_status[0] && !lp_p && !lp_n));

   p_no_direct_lp00_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_p && lp_n) |=> !(!lp_p && !lp_n));

   p_wait_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_status[2] && !(in_valid && clk_lane_go)) |=> lane_status[2]);

   p_stop_is_lp11_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lane_status[2] |-> (lp_p && lp_n && !lane_status[0]));

   p_fixed_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lane_status[0] |-> (!lane_status[3] && !lane_status[1] && !lane_status[2]));

   p_lp_en_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!lp_en_ovr && lane_status[2]) |-> lp_drv_en);
endmodule

bind dlane_hs_tx dlane_hs_tx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .force_stop  (force_stop),
   .clk_lane_go (clk_lane_go),
   .lp_p        (lp_p),
   .lp_n        (lp_n),
   .lp_en_ovr   (lp_en_ovr),
   .lp_drv_en   (lp_drv_en),
   .lane_status (lane_status)
);

// File: tb/dlane_hs_tx_tb.sv
`timescale 1ns/100ps
module dlane_hs_tx_tb;
   localparam int FW = 8;
   localparam int UC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    in_byte = 8'h00;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [4*FW-1:0] hs_times = 32'h0;
   logic [FW-1:0] lpx_units = '0;
   logic          msb_first = 1'b0;
   logic          force_stop = 1'b0;
   logic          hs_en_ovr = 1'b0, hs_en_val = 1'b0;
   logic          lp_en_ovr = 1'b0, lp_en_val = 1'b0;
   logic          clk_lane_go = 1'b0;
   logic          hs_bit, lp_p, lp_n, hs_drv_en, lp_drv_en;
   logic [3:0]    lane_status;

   always #2 clk = ~clk;

   dlane_hs_tx #(.FIELD_W(FW), .UNIT_CYC(UC)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
      .in_ready(in_ready), .hs_times(hs_times), .lpx_units(lpx_units),
      .msb_first(msb_first), .force_stop(force_stop),
      .hs_en_ovr(hs_en_ovr), .hs_en_val(hs_en_val),
      .lp_en_ovr(lp_en_ovr), .lp_en_val(lp_en_val),
      .clk_lane_go(clk_lane_go), .hs_bit(hs_bit), .lp_p(lp_p), .lp_n(lp_n),
      .hs_drv_en(hs_drv_en), .lp_drv_en(lp_drv_en), .lane_status(lane_status)
   );

   int    total = 0, bad = 0, cyc = 0;
   bit    finished = 1'b0;
   string tag = "R1";
   logic [7:0] hostq[$];

   // behavioural lane model: 0 stop,1 lpx,2 prep,3 zero,4 serial,5 trail,6 exit
   int ph = 0, rem = 0;
   bit bq[$];
   bit tbit = 1'b0;

   function automatic int span(int f);
      return ((f == 0) ? 1 : f) * UC;
   endfunction

   task automatic push_bits(logic [7:0] b, bit msb);
      for (int i = 0; i < 8; i++) bq.push_back(msb ? b[7-i] : b[i]);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; rem = 0; bq.delete(); tbit = 1'b0;
      end else if (force_stop) begin
         ph = 0; bq.delete();
      end else begin
         case (ph)
            0: if (in_valid && clk_lane_go) begin ph = 1; rem = span(lpx_units); end
            1: begin rem--; if (rem == 0) begin ph = 2; rem = span(hs_times[31:24]); end end
            2: begin rem--; if (rem == 0) begin ph = 3; rem = span(hs_times[23:16]); end end
            3: begin rem--; if (rem == 0) begin ph = 4; push_bits(8'hB8, msb_first); end end
            4: begin
               bit b;
               b = bq.pop_front();
               if (bq.size() == 0) begin
                  if (in_valid) begin
                     push_bits(in_byte, msb_first);
                     void'(hostq.pop_front());
                  end else begin
                     ph = 5; tbit = !b; rem = span(hs_times[15:8]);
                  end
               end
            end
            5: begin rem--; if (rem == 0) begin ph = 6; rem = span(hs_times[7:0]); end end
            6: begin rem--; if (rem == 0) ph = 0; end
            default: ph = 0;
         endcase
      end
   end

   task automatic chk(input string what, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      bit hsact, e_hs, e_rdy;
      logic [1:0] e_lp;
      hsact = (ph == 3) || (ph == 4) || (ph == 5);
      e_lp  = (ph == 0 || ph == 6) ? 2'b11 : (ph == 1) ? 2'b01 : 2'b00;
      e_hs  = (ph == 4) ? bq[0] : (ph == 5) ? tbit : 1'b0;
      e_rdy = (ph == 4) && (bq.size() == 1) && !force_stop;
      chk("R2 lp lines", {2'b00, lp_p, lp_n}, {2'b00, e_lp});
      chk("R4 hs_bit", {3'b000, hs_bit}, {3'b000, e_hs});
      chk("R6 in_ready", {3'b000, in_ready}, {3'b000, e_rdy});
      chk("R9 hs_drv_en", {3'b000, hs_drv_en}, {3'b000, hs_en_ovr ? hs_en_val : hsact});
      chk("R9 lp_drv_en", {3'b000, lp_drv_en},
          {3'b000, lp_en_ovr ? lp_en_val : (ph == 0 || ph == 1 || ph == 2 || ph == 6)});
      chk("R10 lane_status", lane_status, {1'b0, ph == 0, 1'b0, hsact});
      in_valid = (hostq.size() > 0);
      in_byte  = (hostq.size() > 0) ? hostq[0] : 8'h00;
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000 && !(ph == 0 && hostq.size() == 0); i++) @(negedge clk);
      tick(2);
   endtask

   task automatic wait_busy();
      for (int i = 0; i < 200 && ph == 0; i++) @(negedge clk);
      #1;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         total++; bad++;
         $display("FAIL watchdog all-reqs act=running exp=done");
         summary();
         $finish;
      end
   end

   initial begin
      hs_times = {8'd2, 8'd3, 8'd2, 8'd1};
      lpx_units = 8'd1;
      tag = "R1";
      tick(4);
      rst_n = 1'b1;
      tick(3);

      tag = "R2";                      // no grant: lane must stay in stop
      hostq.push_back(8'h5A); hostq.push_back(8'hA5); hostq.push_back(8'h3C);
      tick(25);
      tag = "R4";
      clk_lane_go = 1'b1;
      wait_busy(); wait_idle();

      tag = "R5";                      // msb first, zero prepare field
      msb_first = 1'b1;
      hs_times = {8'd0, 8'd1, 8'd3, 8'd2};
      lpx_units = 8'd2;
      hostq.push_back(8'h81); hostq.push_back(8'hC3);
      wait_busy(); wait_idle();

      tag = "R3";
      msb_first = 1'b0;
      hs_times = {8'd4, 8'd5, 8'd1, 8'd3};
      lpx_units = 8'd0;
      hostq.push_back(8'hF0);
      wait_busy(); wait_idle();

      tag = "R7";                      // sync byte only, both orders
      hs_times = {8'd1, 8'd1, 8'd2, 8'd2};
      lpx_units = 8'd1;
      for (int k = 0; k < 2; k++) begin
         msb_first = k[0];
         hostq.push_back(8'h11);
         wait_busy();
         hostq.delete();
         wait_idle();
      end
      msb_first = 1'b0;

      tag = "R8";
      for (int k = 0; k < 4; k++) hostq.push_back(8'(8'h21 * (k + 1)));
      wait_busy();
      for (int i = 0; i < 400 && ph != 4; i++) @(negedge clk);
      tick(10);
      force_stop = 1'b1;
      hostq.delete();
      tick(12);
      hostq.push_back(8'h77);          // valid and grant while forced
      tick(15);
      hostq.delete();
      force_stop = 1'b0;
      tick(4);

      tag = "R9";
      hs_en_ovr = 1'b1; hs_en_val = 1'b0; lp_en_ovr = 1'b1; lp_en_val = 1'b1;
      hostq.push_back(8'h96);
      wait_busy(); wait_idle();
      hs_en_val = 1'b1; lp_en_val = 1'b0;
      hostq.push_back(8'h69);
      wait_busy(); wait_idle();
      hs_en_ovr = 1'b0; lp_en_ovr = 1'b0;

      tag = "R6";                      // long back-to-back burst
      for (int k = 0; k < 6; k++) hostq.push_back(8'(8'h0F + 8'(k * 37)));
      wait_busy(); wait_idle();

      tag = "R10";
      msb_first = 1'b1;
      hostq.push_back(8'hE7); hostq.push_back(8'h18);
      wait_busy(); wait_idle();

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule